// File: doc/BRIEF.md
# Closed-Loop Phase-Change Gate Tuner

This block sets one nonvolatile phase-change tuning element to a target optical level by pulsing it, letting it settle, and reading a monitor after each pulse. A request gives a gate address and a target monitor reading. The controller first takes one reading. If the reading is already close enough to the target, the run ends at once. If not, the controller chooses one of two pulse kinds, fires it, waits a programmable number of cycles, and reads the monitor again. The loop ends when the reading lies within a tolerance band around the target, or when a pulse budget is used up.

The two pulse kinds move the element in opposite directions: amorphizing and crystallizing. Each kind has its own amplitude limits and its own pulse length. The crystallizing kind is normally set longer and weaker. The amplitude of each pulse is the error magnitude, shifted right by a configurable amount and then clamped to the limits of the chosen kind. The element keeps its state with no drive, so the pulse-driver outputs go to zero whenever no pulse is in progress. A whole array is reprogrammed by issuing one request per gate, one after another.

Top module: `pcm_tune_ctrl`

## Requirements
- R1: While reset is held and after it is released, `drv_strobe`, `ack`, `ack_ok`, `ack_err`, `drv_amp`, `drv_width`, `drv_kind` and `drv_gate` are all 0.
- R2: An accepted request first takes one monitor sample. If |level − target| ≤ `cfg_tol`, the controller acknowledges with `ack_ok`=1 and `ack_iters`=0, and fires no pulse.
- R3: For a sample outside tolerance, the pulse kind depends on the reading. With `cfg_invert`=0, a reading below the target gives `drv_kind`=1 (amorphize) and a reading above it gives `drv_kind`=0 (crystallize). `cfg_invert`=1 swaps the two.
- R4: `drv_amp` equals (|level − target| >> `cfg_shift`), clamped to the minimum and maximum of the selected kind. Kind 1 uses `cfg_am_amp_min`/`cfg_am_amp_max`; kind 0 uses `cfg_cr_amp_min`/`cfg_cr_amp_max`.
- R5: `drv_strobe` stays high for exactly the width of the selected kind (`cfg_am_width` or `cfg_cr_width`; a width of 0 counts as 1), and `drv_width` shows that value during the pulse.
- R6: After `drv_strobe` falls, monitor samples are ignored for `cfg_settle` cycles. Samples that arrive while the pulse is in progress are also ignored. The first valid sample after that window is used.
- R7: If a sample is outside tolerance after `cfg_max_iter` pulses, the run ends with `ack_err`=1 and `ack_iters`=`cfg_max_iter`. On success, `ack_iters` equals the number of pulses fired.
- R8: `drv_gate` carries the requested address during every pulse of the run.
- R9: A request raised while a run is in progress is ignored.
- R10: Outside a pulse, `drv_amp`, `drv_width`, `drv_kind` and `drv_gate` are 0.
- R11: `ack` is a one-cycle pulse. In that cycle exactly one of `ack_ok` and `ack_err` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a tuning run (taken only when idle) |
| req_gate | input | ADDR_W | Gate address |
| req_target | input | LVL_W | Target monitor reading |
| ack | output | 1 | Run finished (one cycle) |
| ack_ok | output | 1 | Converged within tolerance |
| ack_err | output | 1 | Pulse budget exhausted |
| ack_iters | output | ITER_W | Pulses fired in the run |
| cfg_invert | input | 1 | Swap the pulse-kind sign convention |
| cfg_tol | input | LVL_W | Tolerance half-band |
| cfg_shift | input | SH_W | Right shift from error to amplitude |
| cfg_am_amp_min | input | AMP_W | Amorphize amplitude floor |
| cfg_am_amp_max | input | AMP_W | Amorphize amplitude ceiling |
| cfg_cr_amp_min | input | AMP_W | Crystallize amplitude floor |
| cfg_cr_amp_max | input | AMP_W | Crystallize amplitude ceiling |
| cfg_am_width | input | TMR_W | Amorphize pulse length, cycles |
| cfg_cr_width | input | TMR_W | Crystallize pulse length, cycles |
| cfg_settle | input | TMR_W | Settle delay after a pulse, cycles |
| cfg_max_iter | input | ITER_W | Pulse budget per run |
| drv_strobe | output | 1 | Pulse active |
| drv_kind | output | 1 | 1 amorphize, 0 crystallize |
| drv_amp | output | AMP_W | Pulse amplitude |
| drv_width | output | TMR_W | Pulse length |
| drv_gate | output | ADDR_W | Addressed gate |
| mon_valid | input | 1 | Monitor sample valid |
| mon_level | input | LVL_W | Monitor reading |

## Verification
The end of the settle window and the arrival of a valid monitor sample can fall in the same cycle. The bench provokes this by holding `mon_valid` high through every pulse and every settle cycle, with a decoy reading equal to the target. A sample taken even one cycle early would therefore end the run falsely as converged. This is judged by the final acknowledge: the status and pulse count must match the element model held in the bench, and each pulse's kind and amplitude must follow from the true reading. A second request raised in the middle of a run tests the overlap of a new command with a busy loop. The check is that every later pulse still carries the original gate address.

// File: rtl/pcm_tune_ctrl.sv
module pcm_tune_ctrl #(
  parameter int ADDR_W = 8,
  parameter int LVL_W  = 12,
  parameter int AMP_W  = 10,
  parameter int TMR_W  = 8,
  parameter int ITER_W = 6,
  parameter int SH_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_gate,
  input  logic [LVL_W-1:0]  req_target,
  output logic              ack,
  output logic              ack_ok,
  output logic              ack_err,
  output logic [ITER_W-1:0] ack_iters,
  input  logic              cfg_invert,
  input  logic [LVL_W-1:0]  cfg_tol,
  input  logic [SH_W-1:0]   cfg_shift,
  input  logic [AMP_W-1:0]  cfg_am_amp_min,
  input  logic [AMP_W-1:0]  cfg_am_amp_max,
  input  logic [AMP_W-1:0]  cfg_cr_amp_min,
  input  logic [AMP_W-1:0]  cfg_cr_amp_max,
  input  logic [TMR_W-1:0]  cfg_am_width,
  input  logic [TMR_W-1:0]  cfg_cr_width,
  input  logic [TMR_W-1:0]  cfg_settle,
  input  logic [ITER_W-1:0] cfg_max_iter,
  output logic              drv_strobe,
  output logic              drv_kind,
  output logic [AMP_W-1:0]  drv_amp,
  output logic [TMR_W-1:0]  drv_width,
  output logic [ADDR_W-1:0] drv_gate,
  input  logic              mon_valid,
  input  logic [LVL_W-1:0]  mon_level
);

  localparam int PAD_W = LVL_W - AMP_W;

  typedef enum logic [1:0] {S_IDLE, S_MEAS, S_PULSE, S_SETTLE} st_t;

  st_t               st;
  logic [ADDR_W-1:0] gate_q;
  logic [LVL_W-1:0]  tgt_q;
  logic [ITER_W-1:0] iter_q;
  logic [TMR_W-1:0]  tmr_q;

  logic              above, in_tol, nkind;
  logic [LVL_W-1:0]  diff, scaled, amin, amax;
  logic [AMP_W-1:0]  namp;
  logic [TMR_W-1:0]  nwid, wlen;

  assign above  = mon_level > tgt_q;
  assign diff   = above ? mon_level - tgt_q : tgt_q - mon_level;
  assign in_tol = diff <= cfg_tol;
  assign nkind  = ~above ^ cfg_invert;
  assign scaled = diff >> cfg_shift;
  assign amin   = {{PAD_W{1'b0}}, nkind ? cfg_am_amp_min : cfg_cr_amp_min};
  assign amax   = {{PAD_W{1'b0}}, nkind ? cfg_am_amp_max : cfg_cr_amp_max};
  assign namp   = scaled > amax ? amax[AMP_W-1:0] :
                  scaled < amin ? amin[AMP_W-1:0] : scaled[AMP_W-1:0];
  assign nwid   = nkind ? cfg_am_width : cfg_cr_width;
  assign wlen   = (nwid == '0) ? TMR_W'(1) : nwid;

  assign drv_strobe = (st == S_PULSE);
  assign drv_gate   = drv_strobe ? gate_q : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      gate_q    <= '0;
      tgt_q     <= '0;
      iter_q    <= '0;
      tmr_q     <= '0;
      drv_kind  <= 1'b0;
      drv_amp   <= '0;
      drv_width <= '0;
      ack       <= 1'b0;
      ack_ok    <= 1'b0;
      ack_err   <= 1'b0;
      ack_iters <= '0;
    end else begin
      ack     <= 1'b0;
      ack_ok  <= 1'b0;
      ack_err <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          gate_q <= req_gate;
          tgt_q  <= req_target;
          iter_q <= '0;
          st     <= S_MEAS;
        end
        S_MEAS: if (mon_valid) begin
          if (in_tol || iter_q == cfg_max_iter) begin
            ack       <= 1'b1;
            ack_ok    <= in_tol;
            ack_err   <= ~in_tol;
            ack_iters <= iter_q;
            st        <= S_IDLE;
          end else begin
            drv_kind  <= nkind;
            drv_amp   <= namp;
            drv_width <= wlen;
            tmr_q     <= wlen - TMR_W'(1);
            iter_q    <= iter_q + ITER_W'(1);
            st        <= S_PULSE;
          end
        end
        S_PULSE: begin
          if (tmr_q == '0) begin
            drv_kind  <= 1'b0;
            drv_amp   <= '0;
            drv_width <= '0;
            if (cfg_settle == '0) st <= S_MEAS;
            else begin
              tmr_q <= cfg_settle - TMR_W'(1);
              st    <= S_SETTLE;
            end
          end else tmr_q <= tmr_q - TMR_W'(1);
        end
        S_SETTLE: begin
          if (tmr_q == '0) st <= S_MEAS;
          else tmr_q <= tmr_q - TMR_W'(1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R11
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) ack |=> !ack);
  // R11
  ack_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (ack_ok != ack_err));
  // R7
  iter_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (ack_iters <= cfg_max_iter));
  // R10
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_strobe |-> (drv_amp == '0 && drv_width == '0 && !drv_kind && drv_gate == '0));
  // R4
  amp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drv_strobe |-> (drv_kind ? (drv_amp >= cfg_am_amp_min && drv_amp <= cfg_am_amp_max)
                             : (drv_amp >= cfg_cr_amp_min && drv_amp <= cfg_cr_amp_max)));
  // R5
  pulse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_strobe && $past(drv_strobe)) |-> ($stable(drv_amp) && $stable(drv_kind) && $stable(drv_gate)));
  // R2
  no_ack_in_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drv_strobe |-> !ack);

endmodule

// File: tb/pcm_tune_ctrl_test.sv
module pcm_tune_ctrl_test;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0;
  logic [7:0] req_gate = 0;
  logic [11:0] req_target = 0;
  logic ack, ack_ok, ack_err;
  logic [5:0] ack_iters;
  logic cfg_invert = 0;
  logic [11:0] cfg_tol = 4;
  logic [2:0] cfg_shift = 0;
  logic [9:0] cfg_am_amp_min = 2, cfg_am_amp_max = 400, cfg_cr_amp_min = 1, cfg_cr_amp_max = 150;
  logic [7:0] cfg_am_width = 2, cfg_cr_width = 8, cfg_settle = 3;
  logic [5:0] cfg_max_iter = 30;
  logic drv_strobe, drv_kind;
  logic [9:0] drv_amp;
  logic [7:0] drv_width, drv_gate;
  logic mon_valid = 0;
  logic [11:0] mon_level = 0;

  int nchk = 0, nfail = 0;

  pcm_tune_ctrl uut (.*);

  always #4 clk = ~clk;

  task automatic check(bit ok, string r, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  function automatic int exp_amp(int mag, bit k);
    int s = mag >> cfg_shift;
    int lo = k ? cfg_am_amp_min : cfg_cr_amp_min;
    int hi = k ? cfg_am_amp_max : cfg_cr_amp_max;
    if (s > hi) return hi;
    if (s < lo) return lo;
    return s;
  endfunction

  function automatic int exp_width(bit k);
    int w = k ? cfg_am_width : cfg_cr_width;
    return (w == 0) ? 1 : w;
  endfunction

  task automatic run(int gate, int target, int init, bit stuck, bit inject);
    int lvl = init;
    int pulses = 0, hcnt = 0, decoy = 0, cyc = 0, mag;
    bit prev = 0, k = 0, relbad = 0, ek;
    @(negedge clk);
    req_valid = 1; req_gate = 8'(gate); req_target = 12'(target); mon_valid = 0;
    @(negedge clk);
    req_valid = 0;
    forever begin
      cyc++;
      if (cyc > 20000) begin check(0, "R7 run timeout", cyc, 20000); break; end
      if (ack) begin
        mag = (lvl > target) ? lvl - target : target - lvl;
        if (mag <= cfg_tol) begin
          check(ack_ok && !ack_err, "R11 ok status", {ack_ok, ack_err}, 2);
          check(ack_iters == pulses, "R7 ok pulse count", ack_iters, pulses);
        end else begin
          check(ack_err && !ack_ok, "R7 err status", {ack_ok, ack_err}, 1);
          check(ack_iters == cfg_max_iter && pulses == cfg_max_iter, "R7 budget", ack_iters, cfg_max_iter);
        end
        @(negedge clk);
        check(!ack, "R11 ack one cycle", ack, 0);
        check(!relbad && drv_amp == 0 && !drv_strobe, "R10 release", drv_amp, 0);
        break;
      end
      if (drv_strobe && !prev) begin
        mag = (lvl > target) ? lvl - target : target - lvl;
        ek = (lvl < target) ^ cfg_invert;
        k = drv_kind;
        pulses++;
        hcnt = 1;
        check(drv_kind == ek, "R3 kind", drv_kind, ek);
        check(drv_amp == exp_amp(mag, ek), "R4 amplitude", drv_amp, exp_amp(mag, ek));
        check(drv_width == exp_width(ek), "R5 width port", drv_width, exp_width(ek));
        check(drv_gate == gate, "R8 gate", drv_gate, gate);
        check(pulses <= cfg_max_iter, "R7 no extra pulse", pulses, cfg_max_iter);
      end else if (drv_strobe) hcnt++;
      if (!drv_strobe && prev) begin
        check(hcnt == exp_width(k), "R5 strobe length", hcnt, exp_width(k));
        if (!stuck) begin
          if (k ^ cfg_invert) lvl += int'(drv_amp_last); else lvl -= int'(drv_amp_last);
          if (lvl < 0) lvl = 0;
          if (lvl > 4095) lvl = 4095;
        end
        decoy = cfg_settle;
      end
      if (!drv_strobe && (drv_amp != 0 || drv_width != 0 || drv_kind || drv_gate != 0)) relbad = 1;
      if (drv_strobe) drv_amp_last = drv_amp;
      prev = drv_strobe;
      req_valid = inject && cyc == 3;
      req_gate = 8'(gate ^ 8'h5a);
      if (drv_strobe) begin mon_valid = 1; mon_level = 12'(target); end
      else if (decoy > 0) begin mon_valid = 1; mon_level = 12'(target); decoy--; end
      else begin mon_valid = ($urandom % 4) != 0; mon_level = 12'(lvl); end
      @(negedge clk);
    end
    mon_valid = 0;
    req_valid = 0;
    repeat (2) @(negedge clk);
  endtask

  logic [9:0] drv_amp_last = 0;

  initial begin
    repeat (190000) @(posedge clk);
    check(0, "R1 watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(!drv_strobe && !ack && drv_amp == 0 && drv_gate == 0, "R1 in reset", drv_amp, 0);
    rst_n = 1;
    @(negedge clk);
    check(!drv_strobe && !ack && !ack_ok && !ack_err && drv_width == 0, "R1 after reset", ack, 0);

    // R2: already on target
    run(17, 2000, 2002, 0, 0);
    // R5: zero width counts as one, no settle (R6 boundary)
    cfg_am_width = 0; cfg_cr_width = 0; cfg_settle = 0;
    run(3, 1500, 1200, 0, 0);
    cfg_am_width = 3; cfg_cr_width = 9; cfg_settle = 6;
    // R7: element does not respond
    cfg_max_iter = 3;
    run(9, 1000, 1300, 1, 0);
    // R7: zero budget
    cfg_max_iter = 0;
    run(9, 1000, 900, 0, 0);
    cfg_max_iter = 30;
    // R3: inverted convention
    cfg_invert = 1;
    run(44, 2500, 2100, 0, 0);
    run(45, 2500, 2900, 0, 0);
    cfg_invert = 0;
    // R9: request raised during a run
    run(77, 3000, 2600, 0, 1);

    for (int i = 0; i < 36; i++) begin
      int t = 700 + $urandom % 2600;
      cfg_invert = $urandom % 2;
      cfg_tol = 12'(2 + $urandom % 7);
      cfg_shift = 3'($urandom % 3);
      cfg_am_amp_min = 10'(1 + $urandom % 3); cfg_am_amp_max = 10'(200 + $urandom % 400);
      cfg_cr_amp_min = 10'(1 + $urandom % 2); cfg_cr_amp_max = 10'(100 + $urandom % 200);
      cfg_am_width = 8'(1 + $urandom % 6); cfg_cr_width = 8'(4 + $urandom % 16);
      cfg_settle = 8'($urandom % 11);
      cfg_max_iter = 6'(20 + $urandom % 20);
      run($urandom % 256, t, t - 600 + $urandom % 1200, 0, i % 5 == 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule